// File: doc/BRIEF.md
# Byte-Lane External Bus Bridge

This block joins a 32-bit memory-mapped host port to a slow, asynchronous external bus that several 8-bit peripherals share. The host presents a word address, four byte enables, a read or write request and write data. The block holds the host off with a wait signal until the transfer is done, and then returns the read data. On the external side there is one 20-bit address bus, one bidirectional 8-bit data bus, and a shared pair of active-low read and write strobes. Each peripheral has its own active-low chip select.

Every host access becomes one external byte cycle for each enabled byte lane and for no other lane. A peripheral register that clears itself when read is therefore never touched by a narrower access to a neighbouring byte. Each byte cycle runs through a setup phase, a strobe phase and a hold phase, and a parameter sets the length of each phase in clock cycles so the bus can meet slow device timing. The block also synchronises one active-low interrupt line per peripheral and reports each line separately to the host as an active-high flag.

Top module: `byte_lane_bus_bridge`

## Requirements
- R1: The upper DEV_W bits of host_addr select the device. During a byte cycle, only that device's ext_cs_n bit is low. When no byte cycle is running, all chip selects are high.
- R2: During a byte cycle, ext_addr equals the lower EXT_AW-2 bits of host_addr followed by the 2-bit lane index, which gives contiguous byte addresses.
- R3: For a read, ext_rd_n goes low during the strobe phase. For a write, ext_wr_n goes low during the strobe phase. The two strobes are never low at the same time.
- R4: An access makes exactly one byte cycle for each set bit of host_be. Lanes run in ascending order from lane 0 to lane 3, and lanes whose enable is clear make no cycle.
- R5: Each byte cycle holds the chip select and address for SETUP_CYC cycles before the strobe. The strobe stays low for STROBE_CYC cycles. The chip select then stays low for HOLD_CYC cycles after the strobe. Consecutive byte cycles follow each other with no idle gap.
- R6: host_wait is high while a request is present and not finished. It is low for no request. Counting the clock edge that first sees the request, host_wait goes low after n*(SETUP_CYC+STROBE_CYC+HOLD_CYC)+1 edges, where n is the number of enabled lanes.
- R7: In the cycle where host_wait goes low, host_rdata bits 8k+7..8k hold the byte read for lane k, and lanes that were not enabled read as zero.
- R8: During the write strobe for lane k, ext_data carries host_wdata bits 8k+7..8k. The block releases the data bus at all other times.
- R9: A request with host_be equal to zero finishes after one edge and makes no external cycle.
- R10: host_irq[i] is high when ext_irq_n[i] is low. A two-stage synchroniser places this change two clock edges after the input changes.
- R11: In reset, both strobes and all chip selects are high, host_wait is low and host_irq is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | DEV_W+EXT_AW-2 | Word address: device index on top, word offset below |
| host_be | input | 4 | Byte-lane enables |
| host_rd | input | 1 | Read request |
| host_wr | input | 1 | Write request (wins if both are set) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, lane-steered |
| host_wait | output | 1 | Wait request |
| host_irq | output | NUM_DEV | Synchronised interrupt flags, active high |
| ext_addr | output | EXT_AW | External byte address |
| ext_data | inout | 8 | External data bus |
| ext_rd_n | output | 1 | Shared read strobe, active low |
| ext_wr_n | output | 1 | Shared write strobe, active low |
| ext_cs_n | output | NUM_DEV | Per-device chip selects, active low |
| ext_irq_n | input | NUM_DEV | Per-device interrupt inputs, active low |

## Verification
The bench builds the block with four devices, a 20-bit external address, and phase lengths of 2, 3 and 1 cycles. Because the three phase lengths differ, a swapped or miscounted phase changes a measured width, and the bench measures each strobe width, each setup gap and each trailing hold directly on the pins. The three lengths also make the gap between back-to-back byte cycles (hold plus setup) different from the first setup. With four devices, every chip-select position is covered. A device model returns a data byte that depends on both the device and the address, so a wrong lane, address or select shows up in the steered read data.

// File: rtl/ebb_pkg.sv
package ebb_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef enum logic [1:0] {
        BR_IDLE,
        BR_RUN,
        BR_DONE
    } br_state_e;

    typedef struct packed {
        logic             is_wr;
        logic [LANES-1:0] be;
        logic [31:0]      wdata;
    } req_t;

    // lowest set lane in a mask (0 when empty)
    function automatic logic [LANE_W-1:0] first_lane(input logic [LANES-1:0] m);
        logic [LANE_W-1:0] r;
        r = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (m[i]) r = LANE_W'(i);
        end
        return r;
    endfunction

    function automatic logic [LANES-1:0] lane_bit(input logic [LANE_W-1:0] l);
        return LANES'(1) << l;
    endfunction

endpackage

// File: rtl/ebb_byte_cycle.sv
module ebb_byte_cycle
    import ebb_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_e phase,
    output logic   sample,
    output logic   finish
);
    localparam int MAXC = (SETUP_CYC > STROBE_CYC)
                        ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                        : ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC);
    localparam int CW = (MAXC < 2) ? 1 : $clog2(MAXC);

    logic [CW-1:0] cnt;
    int            lim;
    logic          last;

    always_comb begin
        case (phase)
            PH_SETUP:  lim = SETUP_CYC;
            PH_STROBE: lim = STROBE_CYC;
            PH_HOLD:   lim = HOLD_CYC;
            default:   lim = 1;
        endcase
        last = (int'(cnt) == lim - 1);
    end

    assign sample = (phase == PH_STROBE) && last;
    assign finish = (phase == PH_HOLD) && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (start) phase <= PH_SETUP;
                end
                default: begin
                    if (last) begin
                        cnt <= '0;
                        case (phase)
                            PH_SETUP:  phase <= PH_STROBE;
                            PH_STROBE: phase <= PH_HOLD;
                            default:   phase <= start ? PH_SETUP : PH_IDLE;
                        endcase
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/ebb_cs_decode.sv
module ebb_cs_decode #(
    parameter int NUM_DEV = 4,
    parameter int DEV_W   = 2
) (
    input  logic [DEV_W-1:0]   dev_idx,
    input  logic               active,
    output logic [NUM_DEV-1:0] cs_n
);
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_sel
        assign cs_n[i] = ~(active && (dev_idx == DEV_W'(i)));
    end
endmodule

// File: rtl/ebb_irq_sync.sv
module ebb_irq_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq_n,
    output logic [N-1:0] irq
);
    logic [N-1:0] s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '1;
            s2 <= '1;
        end else begin
            s1 <= irq_n;
            s2 <= s1;
        end
    end

    assign irq = ~s2;
endmodule

// File: rtl/byte_lane_bus_bridge.sv
module byte_lane_bus_bridge
    import ebb_pkg::*;
#(
    parameter int NUM_DEV    = 4,
    parameter int EXT_AW     = 20,
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 1,
    localparam int DEV_W     = (NUM_DEV < 2) ? 1 : $clog2(NUM_DEV),
    localparam int WORD_W    = EXT_AW - LANE_W,
    localparam int IAW       = DEV_W + WORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IAW-1:0]     host_addr,
    input  logic [LANES-1:0]   host_be,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               host_wait,
    output logic [NUM_DEV-1:0] host_irq,
    output logic [EXT_AW-1:0]  ext_addr,
    inout  wire  [7:0]         ext_data,
    output logic               ext_rd_n,
    output logic               ext_wr_n,
    output logic [NUM_DEV-1:0] ext_cs_n,
    input  logic [NUM_DEV-1:0] ext_irq_n
);
    br_state_e         st;
    req_t              req_q;
    logic [IAW-1:0]    addr_q;
    logic [LANES-1:0]  pend_q;
    logic [31:0]       rdata_q;

    phase_e            phase;
    logic              sample, finish, start, active, req_in;
    logic [LANE_W-1:0] cur_lane;
    logic [LANES-1:0]  rem;
    logic [4:0]        lane_ofs;

    assign req_in   = host_rd || host_wr;
    assign cur_lane = first_lane(pend_q);
    assign rem      = pend_q & ~lane_bit(cur_lane);
    assign lane_ofs = {cur_lane, 3'b000};
    assign active   = (phase != PH_IDLE);

    always_comb begin
        start = 1'b0;
        if (st == BR_IDLE && req_in && host_be != '0) start = 1'b1;
        if (st == BR_RUN && finish && rem != '0)      start = 1'b1;
    end

    ebb_byte_cycle #(
        .SETUP_CYC (SETUP_CYC),
        .STROBE_CYC(STROBE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_cycle (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .phase (phase),
        .sample(sample),
        .finish(finish)
    );

    ebb_cs_decode #(
        .NUM_DEV(NUM_DEV),
        .DEV_W  (DEV_W)
    ) u_decode (
        .dev_idx(addr_q[IAW-1:WORD_W]),
        .active (active),
        .cs_n   (ext_cs_n)
    );

    ebb_irq_sync #(
        .N(NUM_DEV)
    ) u_irq (
        .clk  (clk),
        .rst  (rst),
        .irq_n(ext_irq_n),
        .irq  (host_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= BR_IDLE;
            req_q   <= '0;
            addr_q  <= '0;
            pend_q  <= '0;
            rdata_q <= '0;
        end else begin
            case (st)
                BR_IDLE: begin
                    if (req_in) begin
                        addr_q  <= host_addr;
                        req_q   <= '{is_wr: host_wr, be: host_be, wdata: host_wdata};
                        pend_q  <= host_be;
                        rdata_q <= '0;
                        st      <= (host_be == '0) ? BR_DONE : BR_RUN;
                    end
                end
                BR_RUN: begin
                    if (sample && !req_q.is_wr) rdata_q[lane_ofs +: 8] <= ext_data;
                    if (finish) begin
                        pend_q <= rem;
                        if (rem == '0) st <= BR_DONE;
                    end
                end
                default: st <= BR_IDLE;
            endcase
        end
    end

    assign ext_addr   = active ? {addr_q[WORD_W-1:0], cur_lane} : '0;
    assign ext_rd_n   = ~(phase == PH_STROBE && !req_q.is_wr);
    assign ext_wr_n   = ~(phase == PH_STROBE &&  req_q.is_wr);
    assign ext_data   = (phase == PH_STROBE && req_q.is_wr) ? req_q.wdata[lane_ofs +: 8] : 8'hzz;
    assign host_wait  = req_in && (st != BR_DONE);
    assign host_rdata = rdata_q;
endmodule

// File: rtl/ebb_checker.sv
module ebb_checker #(
    parameter int NUM_DEV = 4,
    parameter int EXT_AW  = 20
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_DEV-1:0] ext_cs_n,
    input logic               ext_rd_n,
    input logic               ext_wr_n,
    input logic [EXT_AW-1:0]  ext_addr,
    input logic [3:0]         req_be,
    input logic               host_wait,
    input logic               host_rd,
    input logic               host_wr
);
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ext_cs_n)); // R1

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!ext_rd_n && !ext_wr_n)); // R3

    AST_STROBE_HAS_CS: assert property (@(posedge clk) disable iff (rst)
        (!ext_rd_n || !ext_wr_n) |-> (~ext_cs_n != '0)); // R1

    AST_LANE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (!ext_rd_n || !ext_wr_n) |-> req_be[ext_addr[1:0]]); // R4

    AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        ($fell(ext_rd_n) || $fell(ext_wr_n)) |-> ($past(~ext_cs_n) != '0)); // R5

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!ext_rd_n && $past(!ext_rd_n)) |-> $stable(ext_addr)); // R2

    AST_WAIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        host_wait |-> (host_rd || host_wr)); // R6
endmodule

bind byte_lane_bus_bridge ebb_checker #(
    .NUM_DEV(NUM_DEV),
    .EXT_AW (EXT_AW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ext_cs_n (ext_cs_n),
    .ext_rd_n (ext_rd_n),
    .ext_wr_n (ext_wr_n),
    .ext_addr (ext_addr),
    .req_be   (req_q.be),
    .host_wait(host_wait),
    .host_rd  (host_rd),
    .host_wr  (host_wr)
);

// File: tb/byte_lane_bus_bridge_test.sv
module byte_lane_bus_bridge_test;
    localparam int CLK_PERIOD = 10;
    localparam int ND = 4;
    localparam int AW = 20;
    localparam int SC = 2;
    localparam int TC = 3;
    localparam int HC = 1;
    localparam int P  = SC + TC + HC;
    localparam int WW = AW - 2;
    localparam int IW = 2 + WW;

    logic          clk = 0;
    logic          rst = 1;
    logic [IW-1:0] host_addr = '0;
    logic [3:0]    host_be = '0;
    logic          host_rd = 0, host_wr = 0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    logic          host_wait;
    logic [ND-1:0] host_irq;
    logic [AW-1:0] ext_addr;
    wire  [7:0]    ext_data;
    logic          ext_rd_n, ext_wr_n;
    logic [ND-1:0] ext_cs_n;
    logic [ND-1:0] ext_irq_n = '1;

    int n_chk = 0, n_fail = 0;
    bit timed_out = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_lane_bus_bridge #(
        .NUM_DEV(ND), .EXT_AW(AW), .SETUP_CYC(SC), .STROBE_CYC(TC), .HOLD_CYC(HC)
    ) uut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_be(host_be),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_wait(host_wait), .host_irq(host_irq),
        .ext_addr(ext_addr), .ext_data(ext_data), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n), .ext_cs_n(ext_cs_n), .ext_irq_n(ext_irq_n)
    );

    function automatic logic [7:0] dev_byte(input int d, input logic [AW-1:0] a);
        return 8'(int'(a) * 7 + d * 53 + 90);
    endfunction

    function automatic int sel_dev(input logic [ND-1:0] cs_n);
        int r = -1;
        for (int i = 0; i < ND; i++) if (!cs_n[i]) r = i;
        return r;
    endfunction

    // device model drives the bus while the read strobe is low
    assign ext_data = (!ext_rd_n && ext_cs_n != '1) ? dev_byte(sel_dev(ext_cs_n), ext_addr) : 8'hzz;

    // pin monitor
    int         ev_dev [8];
    logic [AW-1:0] ev_addr [8];
    bit         ev_wr  [8];
    logic [7:0] ev_data [8];
    int         ev_pre [8];
    int         ev_len [8];
    int         n_ev = 0, sc_cnt = 0;
    bit         prev_strobe = 0;

    always @(negedge clk) begin
        bit strobe;
        strobe = !ext_rd_n || !ext_wr_n;
        if (strobe && !prev_strobe) begin
            if (n_ev < 8) begin
                ev_dev[n_ev]  = sel_dev(ext_cs_n);
                ev_addr[n_ev] = ext_addr;
                ev_wr[n_ev]   = !ext_wr_n;
                ev_data[n_ev] = ext_data;
                ev_pre[n_ev]  = sc_cnt;
                ev_len[n_ev]  = 1;
            end
            n_ev++;
            sc_cnt = 0;
        end else if (strobe) begin
            if (n_ev >= 1 && n_ev <= 8) ev_len[n_ev-1]++;
        end else if (ext_cs_n != '1) begin
            sc_cnt++;
        end
        prev_strobe = strobe;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // called at posedge+1
    task automatic access(input bit wr, input int dev, input logic [WW-1:0] word,
                          input logic [3:0] be, input logic [31:0] wd);
        int cnt = 0;
        int nb = 0;
        int k = 0;
        logic [31:0] exp_rd = '0;
        n_ev = 0; sc_cnt = 0;
        host_addr = {2'(dev), word};
        host_be = be; host_wdata = wd;
        host_rd = !wr; host_wr = wr;
        for (int l = 0; l < 4; l++) if (be[l]) nb++;
        do begin
            @(posedge clk); #1;
            cnt++;
        end while (host_wait && cnt < 200);
        if (cnt >= 200) timed_out = 1;
        chk(cnt == nb * P + 1, (be == 0) ? "R9 latency" : "R6 latency", cnt, nb * P + 1);
        chk(n_ev == nb, (be == 0) ? "R9 no cycle" : "R4 cycle count", n_ev, nb);
        for (int l = 0; l < 4; l++) begin
            if (be[l] && k < n_ev && k < 8) begin
                logic [AW-1:0] ea;
                ea = {word, 2'(l)};
                exp_rd[8*l +: 8] = dev_byte(dev, ea);
                chk(ev_dev[k] == dev, "R1 chip select", ev_dev[k], dev);
                chk(ev_addr[k] == ea, "R2/R4 address order", ev_addr[k], ea);
                chk(ev_wr[k] == wr, "R3 strobe kind", ev_wr[k], wr);
                chk(ev_len[k] == TC, "R5 strobe width", ev_len[k], TC);
                chk(ev_pre[k] == ((k == 0) ? SC : HC + SC), "R5 setup gap", ev_pre[k],
                    (k == 0) ? SC : HC + SC);
                if (wr) chk(ev_data[k] == wd[8*l +: 8], "R8 write byte", ev_data[k], wd[8*l +: 8]);
                k++;
            end
        end
        if (nb > 0) chk(sc_cnt == HC, "R5 hold", sc_cnt, HC);
        if (!wr) chk(host_rdata == exp_rd, "R7 read steering", host_rdata, exp_rd);
        host_rd = 0; host_wr = 0;
        @(posedge clk); #1;
        chk(host_wait == 0, "R6 idle wait", host_wait, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        timed_out = 1;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        chk(ext_cs_n == '1, "R11 reset cs", ext_cs_n, 4'hF);
        chk(ext_rd_n && ext_wr_n, "R11 reset strobes", {ext_rd_n, ext_wr_n}, 2'b11);
        chk(host_wait == 0, "R11 reset wait", host_wait, 0);
        chk(host_irq == '0, "R11 reset irq", host_irq, 0);
        rst = 0;
        @(posedge clk); #1;

        // directed: single lanes, full, sparse, empty
        for (int l = 0; l < 4; l++) access(0, l, 18'h2A5A5, 4'(1 << l), 32'h0);
        access(1, 2, 18'h3FFFF, 4'hF, 32'hDEADBEEF);
        access(0, 3, 18'h00001, 4'hF, 32'h0);
        access(0, 1, 18'h12345, 4'b1010, 32'h0);
        access(1, 0, 18'h00000, 4'b0101, 32'hA1B2C3D4);
        access(0, 0, 18'h11111, 4'h0, 32'h0);
        access(1, 3, 18'h22222, 4'h0, 32'hFFFFFFFF);

        // random traffic
        for (int i = 0; i < 60; i++) begin
            access(1'($urandom), int'($urandom % ND), 18'($urandom), 4'($urandom), $urandom);
        end

        // interrupts
        for (int i = 0; i < 4; i++) begin
            logic [ND-1:0] pat;
            logic [ND-1:0] old;
            pat = (i == 0) ? 4'b1010 : 4'($urandom);
            old = host_irq;
            ext_irq_n = pat;
            @(posedge clk); #1;
            chk(host_irq == old, "R10 irq not yet", host_irq, old);
            @(posedge clk); #1;
            chk(host_irq == ~pat, "R10 irq sync", host_irq, ~pat);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule